// File: doc/BRIEF.md
# Flash Command Controller

This block decodes the byte-wide command writes that a host issues to a block-erasable flash device and runs the write state machine behind them. It tracks which data a read would return: array contents, the status register or the identifier. It runs two-step byte-write and block-erase sequences. Programming and erase time come from internal cycle counters, because the memory array is not part of this block.

An erase in progress can be paused on request at a safe point in its count. While it is paused, the host may read or program other blocks and then resume the erase. A resume that arrives while a nested byte write is still running is held until that write finishes. Failures are reported by pairs of error bits in an 8-bit status register:

- a bad confirm code,
- a missing programming voltage,
- a locked target block.

The `ready` output mirrors the busy/idle bit of that register.

The block address is the top `BLK_W` bits of `wr_addr`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, the read mode is array (`rd_mode`=0) and `ready` is 1.
- R2: In idle, data 0xFF selects array mode (0), 0x70 selects status mode (1) and 0x90 selects identifier mode (2). 0x50 clears status bits 5, 4, 3 and 1 and leaves the mode unchanged. Any other code is ignored.
- R3: A byte write is 0x40 or 0x10 followed by a data write. The second write's address and data appear on `op_addr`/`op_data`. Status bit 7 and `ready` stay 0 for exactly `PROG_CYCLES` cycles, and the mode is status from the setup write onward.
- R4: A block erase is 0x20 followed by 0xD0. The controller is then busy for exactly `ERASE_CYCLES` cycles and returns to status 0x80.
- R5: If the write after 0x20 is not 0xD0, status bits 4 and 5 are set and the controller stays ready without erasing.
- R6: If `vpp_ok` is 0 at the second write, bit 3 is set, together with bit 4 for a byte write or bit 5 for an erase, and no busy period follows.
- R7: If the target block's `blk_lock` bit is 1 and `lock_ovr` is 0, bit 1 is set, together with bit 4 for a byte write or bit 5 for an erase, and the operation is aborted. With `lock_ovr`=1 the operation runs.
- R8: Writing 0xB0 during an erase pauses it within 2^`SAFE_LOG2` cycles. While paused, status bits 7 and 6 are 1 and `ready` is 1.
- R9: While paused, only four commands are accepted: 0xFF to a block other than the paused one, 0x70, 0x40/0x10 and 0xD0. Other codes, including 0x50, 0x90 and 0xFF to the paused block, are ignored. A nested byte write to the paused block is refused by setting bit 4.
- R10: During a nested byte write, status bit 7 and `ready` are 0 while bit 6 stays 1.
- R11: 0xD0 while paused clears bit 6 and continues the erase to completion. A 0xD0 written during a nested byte write takes effect only once that write completes.
- R12: Writes other than 0xB0 during an erase, and all writes during a byte write, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write address; top BLK_W bits select the block |
| wr_data | input | 8 | Command or program data byte |
| vpp_ok | input | 1 | Programming voltage is valid |
| lock_ovr | input | 1 | Overrides block lock bits |
| blk_lock | input | 2**BLK_W | Per-block lock bits |
| rd_mode | output | 2 | 0 array, 1 status, 2 identifier |
| status | output | 8 | Status register |
| ready | output | 1 | 1 when the state machine is idle or paused |
| op_addr | output | ADDR_W | Address captured for the current or last operation |
| op_data | output | 8 | Data captured on the byte-write data cycle |

## Verification
The bench targets the resume interlock: it writes 0xD0 in the middle of a nested byte write. A design that resumes at once would show bit 6 clear and the erase running while the write is still busy. It checks that each error pair lands on the right bits and that 0x50 is refused while paused. Getting either wrong shows up as a wrong status byte. It reads and programs the paused block, which a careless design would let corrupt the erase. It also measures exact busy lengths and suspend latency, so an off-by-one counter or a missed safe point yields a wrong cycle count.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W       = 16,
  parameter int BLK_W        = 2,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 40,
  parameter int SAFE_LOG2    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 vpp_ok,
  input  logic                 lock_ovr,
  input  logic [(1<<BLK_W)-1:0] blk_lock,
  output logic [1:0]           rd_mode,
  output logic [7:0]           status,
  output logic                 ready,
  output logic [ADDR_W-1:0]    op_addr,
  output logic [7:0]           op_data
);
  localparam int PC_W = $clog2(PROG_CYCLES + 1);
  localparam int EC_W = $clog2(ERASE_CYCLES + 1);
  localparam int SAFE_STEP = 1 << SAFE_LOG2;
  localparam logic [1:0] M_ARR = 2'd0, M_STAT = 2'd1, M_ID = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_WSET, S_ESET, S_PROG, S_ERASE, S_SUSP, S_SWSET, S_SPROG
  } st_t;

  st_t             state;
  logic [PC_W-1:0] pcnt;
  logic [EC_W-1:0] ecnt;
  logic [BLK_W-1:0] eblk;
  logic            susp_req, resume_req;
  logic            sr5, sr4, sr3, sr1;

  wire [BLK_W-1:0] wblk = wr_addr[ADDR_W-1 -: BLK_W];
  wire blocked  = blk_lock[wblk] && !lock_ovr;
  wire same_blk = (wblk == eblk);
  wire safe     = (ecnt[SAFE_LOG2-1:0] == '0);
  wire d0_now   = wr_en && (wr_data == 8'hD0);
  wire sr6      = (state == S_SUSP) || (state == S_SWSET) || (state == S_SPROG);

  assign ready  = !((state == S_PROG) || (state == S_ERASE) || (state == S_SPROG));
  assign status = {ready, sr6, sr5, sr4, sr3, 1'b0, sr1, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; rd_mode <= M_ARR;
      pcnt <= '0; ecnt <= '0; eblk <= '0;
      susp_req <= 1'b0; resume_req <= 1'b0;
      {sr5, sr4, sr3, sr1} <= '0;
      op_addr <= '0; op_data <= '0;
    end else begin
      case (state)
        S_IDLE: if (wr_en) begin
          case (wr_data)
            8'hFF: rd_mode <= M_ARR;
            8'h70: rd_mode <= M_STAT;
            8'h90: rd_mode <= M_ID;
            8'h50: {sr5, sr4, sr3, sr1} <= '0;
            8'h40, 8'h10: begin state <= S_WSET; rd_mode <= M_STAT; end
            8'h20: begin state <= S_ESET; rd_mode <= M_STAT; end
            default: ;
          endcase
        end
        S_WSET: if (wr_en) begin
          op_addr <= wr_addr; op_data <= wr_data;
          if (!vpp_ok)      begin sr3 <= 1'b1; sr4 <= 1'b1; state <= S_IDLE; end
          else if (blocked) begin sr1 <= 1'b1; sr4 <= 1'b1; state <= S_IDLE; end
          else begin state <= S_PROG; pcnt <= PC_W'(PROG_CYCLES - 1); end
        end
        S_ESET: if (wr_en) begin
          if (wr_data != 8'hD0) begin sr4 <= 1'b1; sr5 <= 1'b1; state <= S_IDLE; end
          else if (!vpp_ok)     begin sr3 <= 1'b1; sr5 <= 1'b1; state <= S_IDLE; end
          else if (blocked)     begin sr1 <= 1'b1; sr5 <= 1'b1; state <= S_IDLE; end
          else begin
            state <= S_ERASE; ecnt <= EC_W'(ERASE_CYCLES - 1);
            eblk <= wblk; op_addr <= wr_addr;
          end
        end
        S_PROG: if (pcnt == '0) state <= S_IDLE; else pcnt <= pcnt - 1'b1;
        S_ERASE: begin
          if (wr_en && wr_data == 8'hB0) susp_req <= 1'b1;
          if (ecnt == '0) begin state <= S_IDLE; susp_req <= 1'b0; end
          else if (susp_req && safe) begin state <= S_SUSP; susp_req <= 1'b0; end
          else ecnt <= ecnt - 1'b1;
        end
        S_SUSP: if (wr_en) begin
          case (wr_data)
            8'hFF: if (!same_blk) rd_mode <= M_ARR;
            8'h70: rd_mode <= M_STAT;
            8'h40, 8'h10: begin state <= S_SWSET; rd_mode <= M_STAT; end
            8'hD0: begin state <= S_ERASE; rd_mode <= M_STAT; end
            default: ;
          endcase
        end
        S_SWSET: if (wr_en) begin
          op_addr <= wr_addr; op_data <= wr_data;
          if (same_blk)     begin sr4 <= 1'b1; state <= S_SUSP; end
          else if (!vpp_ok) begin sr3 <= 1'b1; sr4 <= 1'b1; state <= S_SUSP; end
          else if (blocked) begin sr1 <= 1'b1; sr4 <= 1'b1; state <= S_SUSP; end
          else begin state <= S_SPROG; pcnt <= PC_W'(PROG_CYCLES - 1); end
        end
        S_SPROG: begin
          if (d0_now) resume_req <= 1'b1;
          if (pcnt == '0) begin
            state <= (resume_req || d0_now) ? S_ERASE : S_SUSP;
            resume_req <= 1'b0;
          end else pcnt <= pcnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [EC_W:0] susp_wait;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) susp_wait <= '0;
    else if (state == S_ERASE && susp_req) susp_wait <= susp_wait + 1'b1;
    else susp_wait <= '0;
  end

  assert_busy_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(wr_en));
  assert_err_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> $past(wr_en));
  assert_clear_only_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[5]) |-> $past(wr_en && wr_data == 8'h50));
  assert_pause_on_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(susp_req));
  assert_pause_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_wait <= (EC_W+1)'(SAFE_STEP));
  assert_resume_interlock_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ERASE && $past(state == S_SPROG)) |-> $past(pcnt == '0));
endmodule

// File: tb/flash_cmd_ctrl_bench.sv
module flash_cmd_ctrl_bench;
  localparam int ADDR_W = 16, BLK_W = 2, PROG_CYCLES = 6, ERASE_CYCLES = 40, SAFE_LOG2 = 2;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, vpp_ok = 1'b1, lock_ovr = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [(1<<BLK_W)-1:0] blk_lock = '0;
  logic [1:0] rd_mode;
  logic [7:0] status, op_data;
  logic ready;
  logic [ADDR_W-1:0] op_addr;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYCLES(PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES), .SAFE_LOG2(SAFE_LOG2)) u_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vpp_ok(vpp_ok), .lock_ovr(lock_ovr), .blk_lock(blk_lock), .rd_mode(rd_mode),
    .status(status), .ready(ready), .op_addr(op_addr), .op_data(op_data));

  typedef struct { string tag; logic [7:0] st; logic [1:0] md; logic rdy; } item_t;
  item_t q[$];
  event chk_ev;
  int total = 0, bad = 0;

  task automatic expect_out(string tag, logic [7:0] st, logic [1:0] md, logic rdy);
    item_t it;
    it.tag = tag; it.st = st; it.md = md; it.rdy = rdy;
    q.push_back(it);
    -> chk_ev;
    #0;
  endtask

  initial forever begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (status !== it.st || rd_mode !== it.md || ready !== it.rdy) begin
        bad++;
        $display("FAIL %s: status=%h mode=%0d ready=%b expected status=%h mode=%0d ready=%b",
                 it.tag, status, rd_mode, ready, it.st, it.md, it.rdy);
      end
    end
  end

  task automatic cmp(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready && n < 1000) begin n++; @(negedge clk); end
  endtask

  int n;
  initial begin
    repeat (3) @(negedge clk);
    expect_out("R1 reset", 8'h80, 2'd0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);

    wr(16'h0, 8'h70); expect_out("R2 status mode", 8'h80, 2'd1, 1'b1);
    wr(16'h0, 8'h90); expect_out("R2 id mode", 8'h80, 2'd2, 1'b1);
    wr(16'h0, 8'h33); expect_out("R2 unknown ignored", 8'h80, 2'd2, 1'b1);
    wr(16'h0, 8'hFF); expect_out("R2 array mode", 8'h80, 2'd0, 1'b1);

    wr(16'h1234, 8'h40); expect_out("R3 setup", 8'h80, 2'd1, 1'b1);
    wr(16'h1234, 8'hA5); expect_out("R3 busy", 8'h00, 2'd1, 1'b0);
    busy_len(n); cmp("R3 program length", n, PROG_CYCLES);
    cmp("R3 addr", op_addr, 16'h1234); cmp("R3 data", op_data, 8'hA5);
    expect_out("R3 done", 8'h80, 2'd1, 1'b1);

    wr(16'h0100, 8'h10); wr(16'h0100, 8'h3C);
    wr(16'h0, 8'hFF); expect_out("R12 ignored in write", 8'h00, 2'd1, 1'b0);
    busy_len(n); cmp("R3 alt data", op_data, 8'h3C);
    expect_out("R3 alt done", 8'h80, 2'd1, 1'b1);

    vpp_ok = 1'b0;
    wr(16'h0, 8'h40); wr(16'h0, 8'h11); expect_out("R6 write vpp", 8'h98, 2'd1, 1'b1);
    wr(16'h0, 8'h50); expect_out("R2 clear", 8'h80, 2'd1, 1'b1);
    wr(16'h0, 8'h20); wr(16'h0, 8'hD0); expect_out("R6 erase vpp", 8'hA8, 2'd1, 1'b1);
    wr(16'h0, 8'h50); vpp_ok = 1'b1;

    blk_lock = 4'b0010;
    wr(16'h4000, 8'h40); wr(16'h4000, 8'h22); expect_out("R7 write locked", 8'h92, 2'd1, 1'b1);
    wr(16'h0, 8'h50);
    wr(16'h4000, 8'h20); wr(16'h4000, 8'hD0); expect_out("R7 erase locked", 8'hA2, 2'd1, 1'b1);
    wr(16'h0, 8'h50);
    lock_ovr = 1'b1;
    wr(16'h4000, 8'h40); wr(16'h4000, 8'h22); expect_out("R7 override runs", 8'h00, 2'd1, 1'b0);
    busy_len(n); lock_ovr = 1'b0;

    wr(16'h0, 8'hFF);
    wr(16'h0, 8'h20); wr(16'h0, 8'h33); expect_out("R5 bad confirm", 8'hB0, 2'd1, 1'b1);
    wr(16'h0, 8'h50); expect_out("R5 cleared", 8'h80, 2'd1, 1'b1);

    wr(16'h8000, 8'h20); wr(16'h8000, 8'hD0); expect_out("R4 erase busy", 8'h00, 2'd1, 1'b0);
    busy_len(n); cmp("R4 erase length", n + 0, ERASE_CYCLES);
    expect_out("R4 erase done", 8'h80, 2'd1, 1'b1);

    wr(16'h8000, 8'h20); wr(16'h8000, 8'hD0);
    wr(16'h0, 8'h90); expect_out("R12 ignored in erase", 8'h00, 2'd1, 1'b0);
    wr(16'h0, 8'hB0);
    busy_len(n);
    total++;
    if (n > (1 << SAFE_LOG2)) begin bad++; $display("FAIL R8 latency: actual=%0d expected<=%0d", n, 1 << SAFE_LOG2); end
    expect_out("R8 paused", 8'hC0, 2'd1, 1'b1);
    wr(16'h8000, 8'hFF); expect_out("R9 same block read refused", 8'hC0, 2'd1, 1'b1);
    wr(16'h0, 8'h90); expect_out("R9 id refused", 8'hC0, 2'd1, 1'b1);
    wr(16'h0, 8'hFF); expect_out("R9 other block read", 8'hC0, 2'd0, 1'b1);
    wr(16'h0, 8'h70); expect_out("R9 status", 8'hC0, 2'd1, 1'b1);
    wr(16'h0, 8'h40); wr(16'h0010, 8'h5A); expect_out("R10 nested write", 8'h40, 2'd1, 1'b0);
    wr(16'h0, 8'hD0); expect_out("R11 resume held", 8'h40, 2'd1, 1'b0);
    n = 0;
    while (status[6] && n < 100) begin n++; @(negedge clk); end
    cmp("R10 nested data", op_data, 8'h5A);
    expect_out("R11 erase resumed", 8'h00, 2'd1, 1'b0);
    busy_len(n); expect_out("R11 erase finished", 8'h80, 2'd1, 1'b1);

    wr(16'h8000, 8'h20); wr(16'h8000, 8'hD0); wr(16'h0, 8'hB0);
    busy_len(n);
    wr(16'h0, 8'h40); wr(16'h8004, 8'h77); expect_out("R9 paused block write refused", 8'hD0, 2'd1, 1'b1);
    wr(16'h0, 8'h50); expect_out("R9 clear refused", 8'hD0, 2'd1, 1'b1);
    wr(16'h0, 8'hD0); expect_out("R11 resume", 8'h10, 2'd1, 1'b0);
    busy_len(n); expect_out("R11 done keeps error", 8'h90, 2'd1, 1'b1);
    wr(16'h0, 8'h50); expect_out("R2 final clear", 8'h80, 2'd1, 1'b1);

    #1;
    if (q.size() != 0) begin bad++; $display("FAIL scoreboard: actual=%0d expected=0 pending", q.size()); end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule